// File: doc/BRIEF.md
# Reference-Pattern Current Anomaly Detector

This block watches a stream of supply-current samples, each qualified by a valid strobe, and decides whether the monitored target draws current the way it did while it was known to be healthy. A capture command starts a learning phase. During that phase the next `DEPTH` valid samples are stored as a reference window, and the largest of them is tracked. When the window is full, the block computes an allowed deviation once. That deviation is the programmed error-rate percentage of the largest reference value, in integer units, with the division truncating. After that the block reports that capture is complete and switches to monitoring.

While monitoring, the reference window is replayed endlessly in its stored order, one entry per live sample, and wraps back to the first entry after the last. Each live sample is compared with its aligned reference entry. The signed difference (live minus reference) is presented on an output. The sample is flagged when the magnitude of that difference is strictly larger than the allowed deviation. A run-length filter counts flagged samples in a row, and any in-range sample clears the count. A one-cycle malfunction pulse is raised on the sample that brings the run to `RUNLEN`. The pulse is not raised again until the run has been broken. Short transient bursts therefore never raise an alarm.

Top module: `cur_anomaly_mon`

## Requirements
- R1: After reset, `cap_done`, `flag`, `malfunc` and `err` are all 0. The block stays idle, and valid samples cause no output change until a capture command has been given.
- R2: After a `cap_start` pulse, the next `DEPTH` valid samples fill the reference window. `cap_done` goes to 1 in the cycle that follows the edge that accepted the `DEPTH`-th of these samples. While `cap_done` is 0, `flag` and `malfunc` stay 0.
- R3: Once `cap_done` is 1, the k-th valid live sample (counting from 0) is compared with reference entry k mod `DEPTH`, where entry 0 is the first captured sample.
- R4: For each monitored sample, `err` becomes live minus reference, as a two's-complement value `SW+1` bits wide. It is visible from the cycle after the edge that accepted the sample.
- R5: The allowed deviation is floor(max_ref × rate / 100). Here max_ref is the largest captured sample, and rate is the `err_rate` value on the edge that accepts the last capture sample. Later changes to `err_rate` have no effect. `flag` is 1 exactly when |err| is strictly greater than the allowed deviation, so this covers both positive and negative errors.
- R6: A run counter increments on each flagged sample and is cleared to 0 by any in-range sample. `malfunc` is high for exactly one cycle, on the sample whose flag makes the run length equal to `RUNLEN`. Runs shorter than `RUNLEN` never raise it.
- R7: Once a run has raised `malfunc`, further flagged samples in the same run raise no further pulses. A new pulse needs an in-range sample first, followed by a fresh run of `RUNLEN` flagged samples.
- R8: A `cap_start` pulse clears `cap_done`, `flag`, `err`, `malfunc`, the run count, the maximum and the window position, and restarts capture. When `cap_start` and `samp_valid` are high on the same edge, the sample is discarded and is not stored as reference entry 0.
- R9: Cycles with `samp_valid` low (and no `cap_start`) leave `flag`, `err` and `cap_done` unchanged and do not advance the replay position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Qualifies `samp_data` for one cycle |
| samp_data | input | SW | Unsigned current sample |
| cap_start | input | 1 | Starts a new reference capture |
| err_rate | input | RATEW | Allowed deviation in percent of the reference maximum |
| flag | output | 1 | Last monitored sample was out of range |
| err | output | SW+1 | Signed difference of the last monitored sample from its reference |
| cap_done | output | 1 | Reference window captured; monitoring active |
| malfunc | output | 1 | One-cycle malfunction pulse |

## Verification
The bench builds the block with `SW`=12, `DEPTH`=16, `RATEW`=7 and `RUNLEN`=5. With these values the replay wraps many times within a short run, and runs of one below, equal to and beyond the run limit occur often under random burst lengths. Directed phases place live values exactly at and one past the allowed deviation, on both sides of the reference. They include the 90-unit, 10 % case and a 95-unit, 15 % case whose product truncates. They also change the rate after capture, and issue a recapture that coincides with a valid sample in the middle of a run.

// File: rtl/cur_anomaly_mon.sv
module cur_anomaly_mon #(
  parameter int SW     = 12,
  parameter int DEPTH  = 100,
  parameter int RATEW  = 7,
  parameter int RUNLEN = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp_valid,
  input  logic [SW-1:0]        samp_data,
  input  logic                 cap_start,
  input  logic [RATEW-1:0]     err_rate,
  output logic                 flag,
  output logic signed [SW:0]   err,
  output logic                 cap_done,
  output logic                 malfunc
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(RUNLEN + 1);
  localparam int EW = SW + 1;
  localparam int PW = SW + RATEW;

  logic [SW-1:0]        ref_mem [DEPTH];
  logic [IW-1:0]        idx;
  logic [SW-1:0]        max_q;
  logic [PW-1:0]        thr_q;
  logic [CW-1:0]        run_cnt;
  logic                 capturing;

  logic [SW-1:0]        ref_s;
  logic signed [EW-1:0] diff;
  logic [EW-1:0]        mag;
  logic                 over;
  logic [SW-1:0]        max_nx;
  logic [PW-1:0]        thr_nx;
  logic                 last;

  assign ref_s  = ref_mem[idx];
  assign diff   = $signed({1'b0, samp_data}) - $signed({1'b0, ref_s});
  assign mag    = diff[EW-1] ? EW'(-diff) : EW'(diff);
  assign over   = PW'(mag) > thr_q;
  assign max_nx = (samp_data > max_q) ? samp_data : max_q;
  assign thr_nx = (PW'(max_nx) * PW'(err_rate)) / PW'(100);
  assign last   = (idx == IW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || cap_start) begin
      capturing <= rst_n;
      cap_done  <= 1'b0;
      idx       <= '0;
      max_q     <= '0;
      run_cnt   <= '0;
      flag      <= 1'b0;
      err       <= '0;
      malfunc   <= 1'b0;
      if (!rst_n) thr_q <= '0;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] <= '0;
    end else begin
      malfunc <= 1'b0;
      if (samp_valid) begin
        if (capturing) begin
          ref_mem[idx] <= samp_data;
          max_q        <= max_nx;
          if (last) begin
            capturing <= 1'b0;
            cap_done  <= 1'b1;
            thr_q     <= thr_nx;
            idx       <= '0;
          end else begin
            idx <= idx + IW'(1);
          end
        end else if (cap_done) begin
          flag <= over;
          err  <= diff;
          idx  <= last ? '0 : idx + IW'(1);
          if (over) begin
            if (run_cnt < CW'(RUNLEN)) begin
              run_cnt <= run_cnt + CW'(1);
              if (run_cnt == CW'(RUNLEN - 1)) malfunc <= 1'b1;
            end
          end else begin
            run_cnt <= '0;
          end
        end
      end
    end
  end

  assert_quiet_before_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |-> (!flag && !malfunc));

  assert_pulse_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    malfunc |-> flag);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    malfunc |=> !malfunc);

  assert_run_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RUNLEN));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(samp_valid) && !$past(cap_start)) |-> ($stable(flag) && $stable(err) && $stable(cap_done)));

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_start) |-> (!cap_done && !flag && err == '0));

endmodule

// File: tb/cur_anomaly_mon_tb_top.sv
module cur_anomaly_mon_tb_top;
  localparam int SW = 12, DEPTH = 16, RATEW = 7, RUNLEN = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic samp_valid = 1'b0, cap_start = 1'b0;
  logic [SW-1:0] samp_data = '0;
  logic [RATEW-1:0] err_rate = '0;
  logic flag, cap_done, malfunc;
  logic signed [SW:0] err;

  cur_anomaly_mon #(.SW(SW), .DEPTH(DEPTH), .RATEW(RATEW), .RUNLEN(RUNLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .cap_start(cap_start), .err_rate(err_rate), .flag(flag), .err(err),
    .cap_done(cap_done), .malfunc(malfunc));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int cycles = 0;
  bit finished = 0;

  int mref [DEPTH];
  int mmax, mthr, midx, mcnt, merr;
  bit mcap, mdone, mflag, mmal;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(int v);
    if (v < 0) return 0;
    if (v > (1 << SW) - 1) return (1 << SW) - 1;
    return v;
  endfunction

  task automatic model(bit v, int d, bit c);
    int e, a;
    if (c) begin
      mcap = 1; mdone = 0; midx = 0; mmax = 0; mcnt = 0;
      mflag = 0; merr = 0; mmal = 0;
    end else begin
      mmal = 0;
      if (v && mcap) begin
        mref[midx] = d;
        if (d > mmax) mmax = d;
        if (midx == DEPTH - 1) begin
          mcap = 0; mdone = 1; midx = 0;
          mthr = (mmax * int'(err_rate)) / 100;
        end else midx++;
      end else if (v && mdone) begin
        e = d - mref[midx];
        a = (e < 0) ? -e : e;
        mflag = (a > mthr);
        merr = e;
        midx = (midx == DEPTH - 1) ? 0 : midx + 1;
        if (mflag) begin
          if (mcnt < RUNLEN) begin
            mcnt++;
            if (mcnt == RUNLEN) mmal = 1;
          end
        end else mcnt = 0;
      end
    end
  endtask

  task automatic step(bit v, int d, bit c, string tag);
    @(negedge clk);
    samp_valid = v; samp_data = SW'(d); cap_start = c;
    model(v, d, c);
    @(negedge clk);
    samp_valid = 0; cap_start = 0;
    chk({tag, " R2 cap_done"}, int'(cap_done), int'(mdone));
    chk({tag, " R5 flag"}, int'(flag), int'(mflag));
    chk({tag, " R3/R4 err"}, int'(err), merr);
    chk({tag, " R6/R7 malfunc"}, int'(malfunc), int'(mmal));
  endtask

  task automatic mon(int off, string tag);
    step(1, clampv(mref[midx] + off), 0, tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, tag);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    mcap = 0; mdone = 0; midx = 0; mmax = 0; mthr = 0; mcnt = 0;
    mflag = 0; merr = 0; mmal = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cap_done", int'(cap_done), 0);
    chk("R1 reset flag", int'(flag), 0);
    chk("R1 reset malfunc", int'(malfunc), 0);
    chk("R1 reset err", int'(err), 0);
    for (int i = 0; i < 4; i++) step(1, 3000, 0, "R1 idle sample");

    err_rate = 10;
    step(0, 0, 1, "R8 start A");
    for (int i = 0; i < DEPTH; i++) begin
      step(1, (i == 7) ? 90 : 80 + (i % 5) * 2, 0, "R2 capture A");
      if (i == 3) idle("R9 capture gap");
    end
    err_rate = 100;
    mon(9, "R5 edge 90/10 in");
    mon(10, "R5 edge 90/10 out");
    mon(-10, "R5 negative out");
    mon(-9, "R5 negative in");
    for (int i = 0; i < RUNLEN - 1; i++) mon(40, "R6 short burst");
    idle("R9 idle in run");
    mon(0, "R6 clear");
    for (int i = 0; i < RUNLEN + 3; i++) begin
      mon(50, "R7 long run");
      if (i == 2) idle("R9 idle keeps run");
    end
    mon(1, "R7 break");
    for (int i = 0; i < RUNLEN; i++) mon(-60, "R7 rearm");
    for (int i = 0; i < 2 * DEPTH; i++) mon((i % 3) - 1, "R3 wrap");

    for (int i = 0; i < 2; i++) mon(70, "R8 pre-restart run");
    err_rate = 15;
    step(1, 4000, 1, "R8 start B with sample");
    for (int i = 0; i < DEPTH; i++)
      step(1, (i == 11) ? 95 : 60 + i, 0, "R2 capture B");
    err_rate = 1;
    mon(14, "R5 trunc in");
    mon(15, "R5 trunc out");
    mon(-14, "R5 trunc neg in");
    mon(-15, "R5 trunc neg out");
    for (int i = 0; i < RUNLEN; i++) mon(30, "R6 run B");

    for (int r = 0; r < 3; r++) begin
      err_rate = RATEW'(1 + $urandom_range(0, 39));
      step(0, 0, 1, "R8 start random");
      for (int i = 0; i < DEPTH; i++)
        step(1, 200 + $urandom_range(0, 2800), 0, "R2 capture random");
      err_rate = RATEW'($urandom_range(0, 100));
      for (int k = 0; k < 150; k++) begin
        int len, mag;
        len = $urandom_range(1, RUNLEN + 2);
        mag = mthr + 1 + $urandom_range(0, 200);
        for (int j = 0; j < len; j++) begin
          mon(($urandom_range(0, 1) == 1) ? mag : -mag, "R6 random burst");
          if ($urandom_range(0, 7) == 0) idle("R9 random idle");
        end
        mon($urandom_range(0, 2 * mthr) - mthr, "R6 random in-range");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule